// File: doc/BRIEF.md
# Saturation and Bit-Search Unit

This unit performs one of three data operations for a 32-bit processor datapath and hands the result back one clock later. Two of the operations clamp a signed 32-bit word to a narrower signed range, 16 bits or 24 bits. The clamped value stays sign-extended to the full 32 bits. The third operation is a bit-search test. It shifts the source word left by a 5-bit amount and reports only whether any set bit survives the shift. The surrounding pipeline takes the registered result and its write enable into its register file. It takes the carry value and its write enable into its status register.

An operation is issued by pulsing `in_valid` with an operation code, a source word and a shift word. A two-state controller tracks issue. In ST_IDLE no result is pending. The transition GO_EMIT, taken whenever `in_valid` is sampled high, enters ST_EMIT. In ST_EMIT the registered outputs are valid. From ST_EMIT, the transition HOLD_EMIT keeps the controller in ST_EMIT when another strobe arrives. The transition BACK_IDLE returns it to ST_IDLE when no strobe arrives. Operation codes are 0 for the 16-bit clamp, 1 for the 24-bit clamp, 2 for the bit-search test and 3 for no operation.

Top module: `satbs_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid`, `res_we` and `carry_we` are low.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high. Issues on consecutive cycles keep it high without a gap.
- R3: Op code 0 (16-bit clamp) with a signed source above 0x00007FFF gives `res` = 0x00007FFF.
- R4: Op code 0 with a signed source below -0x8000 gives `res` = 0xFFFF8000. A source within [-0x8000, 0x7FFF] passes through unchanged.
- R5: Op code 1 (24-bit clamp) limits the signed source to [-0x800000, 0x7FFFFF]. Out-of-range values give 0x007FFFFF or 0xFF800000, and in-range values pass unchanged.
- R6: Both clamp ops assert `res_we` and keep `carry_we` low, so no flag is changed.
- R7: Op code 2 (bit-search) drives `carry` to 1 exactly when `src << amt[4:0]`, truncated to 32 bits, is non-zero. It asserts `carry_we` and keeps `res_we` low.
- R8: Bits 31..5 of `amt` have no effect. An amount of 32 behaves as a shift of zero.
- R9: Op code 3 produces `out_valid` with both `res_we` and `carry_we` low. The two write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for one operation |
| op | input | 2 | Operation code (0 clamp16, 1 clamp24, 2 bit-search, 3 none) |
| src | input | 32 | Source word |
| amt | input | 32 | Shift word; only bits 4..0 are used |
| out_valid | output | 1 | Registered outputs belong to the previous issue |
| res | output | 32 | Clamped, sign-extended result |
| res_we | output | 1 | Result should be written to the destination register |
| carry | output | 1 | New carry flag value |
| carry_we | output | 1 | Carry flag should be updated |

## Verification
The assertions check four things on every cycle. They check the one-cycle relation between `in_valid` and `out_valid` in both directions. They check that a write enable never appears without `out_valid` and that the two enables are exclusive. They also check that any written clamp result fits its target width. Only the bench scenarios can show the exact values. These are the limit constants at and just beyond each boundary, pass-through of in-range values, the carry outcome for every bit position against every shift amount, and the masking of the upper shift bits.

// File: rtl/satbs_pkg.sv
package satbs_pkg;

    typedef enum logic [1:0] {
        OP_CLAMP16 = 2'd0,
        OP_CLAMP24 = 2'd1,
        OP_BSCH    = 2'd2,
        OP_NONE    = 2'd3
    } satbs_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } satbs_state_e;

endpackage

// File: rtl/satbs_clamp.sv
module satbs_clamp #(
    parameter int W = 32,
    parameter int N = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int TOPW = W - N + 1;

    logic [TOPW-1:0] top_bits;
    logic            fits;

    assign top_bits = din[W-1:N-1];
    assign fits     = (&top_bits) | ~(|top_bits);

    always_comb begin
        if (fits) begin
            dout = din;
        end else if (din[W-1]) begin
            dout = {{TOPW{1'b1}}, {(N-1){1'b0}}};
        end else begin
            dout = {{TOPW{1'b0}}, {(N-1){1'b1}}};
        end
    end

    // R5: clamp output always representable in N signed bits
    always_comb begin
        if (!$isunknown(din)) begin
            p_clamp_fit_r5: assert ((&dout[W-1:N-1]) | ~(|dout[W-1:N-1]))
                else $error("clamp output out of range");
        end
    end
endmodule

// File: rtl/satbs_bsch.sv
module satbs_bsch #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] amt,
    output logic         nz
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    logic [W-1:0]   shifted;

    assign sh      = amt[SHW-1:0];
    assign shifted = din << sh;
    assign nz      = |shifted;
endmodule

// File: rtl/satbs_unit.sv
module satbs_unit
    import satbs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] amt,
    output logic         out_valid,
    output logic [W-1:0] res,
    output logic         res_we,
    output logic         carry,
    output logic         carry_we
);
    localparam int N16 = 16;
    localparam int N24 = 24;

    satbs_state_e state_q, state_d;
    satbs_op_e    op_sel;
    logic [W-1:0] c16, c24;
    logic         srch_nz;

    assign op_sel = satbs_op_e'(op);

    satbs_clamp #(.W(W), .N(N16)) u_clamp16 (.din(src), .dout(c16));
    satbs_clamp #(.W(W), .N(N24)) u_clamp24 (.din(src), .dout(c24));
    satbs_bsch  #(.W(W))          u_bsch    (.din(src), .amt(amt), .nz(srch_nz));

    // next-state: GO_EMIT / HOLD_EMIT / BACK_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res      <= '0;
            res_we   <= 1'b0;
            carry    <= 1'b0;
            carry_we <= 1'b0;
        end else if (in_valid) begin
            unique case (op_sel)
                OP_CLAMP16: begin
                    res <= c16; res_we <= 1'b1; carry <= 1'b0; carry_we <= 1'b0;
                end
                OP_CLAMP24: begin
                    res <= c24; res_we <= 1'b1; carry <= 1'b0; carry_we <= 1'b0;
                end
                OP_BSCH: begin
                    res <= '0; res_we <= 1'b0; carry <= srch_nz; carry_we <= 1'b1;
                end
                default: begin
                    res <= '0; res_we <= 1'b0; carry <= 1'b0; carry_we <= 1'b0;
                end
            endcase
        end else begin
            res_we   <= 1'b0;
            carry_we <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    p_issue_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("missing out_valid");

    p_valid_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)) else $error("spurious out_valid");

    p_we_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || carry_we) |-> out_valid) else $error("write enable without valid");

    p_we_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_we && carry_we)) else $error("both write enables high");

    p_clamp16_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && $past(op) == 2'd0) |-> ((&res[W-1:N16-1]) || !(|res[W-1:N16-1])))
        else $error("16-bit clamp result out of range");
endmodule

// File: tb/satbs_unit_bench.sv
module satbs_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] src = '0;
    logic [31:0] amt = '0;
    logic        out_valid, res_we, carry, carry_we;
    logic [31:0] res;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    satbs_unit u_satbs_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src), .amt(amt),
        .out_valid(out_valid), .res(res), .res_we(res_we), .carry(carry), .carry_we(carry_we)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_clamp(input logic [31:0] v, input int n);
        longint sv, hi, lo;
        sv = longint'($signed(v));
        hi = (64'sd1 <<< (n - 1)) - 1;
        lo = -(hi + 1);
        if (sv > hi) return hi[31:0];
        if (sv < lo) return lo[31:0];
        return v;
    endfunction

    task automatic issue(input logic [1:0] o, input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        op = o; src = s; amt = a; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic clamp_case(input logic [31:0] v);
        logic [31:0] e;
        e = exp_clamp(v, 16);
        issue(2'd0, v, 32'd0);
        chk(res == e, ($signed(v) > 32'sh7FFF) ? "R3 clamp16 high" : "R4 clamp16 low/pass", res, e);
        chk(out_valid && res_we && !carry_we, "R6 clamp16 enables", {29'd0, out_valid, res_we, carry_we}, 32'd6);
        e = exp_clamp(v, 24);
        issue(2'd1, v, 32'd0);
        chk(res == e, "R5 clamp24 value", res, e);
        chk(out_valid && res_we && !carry_we, "R6 clamp24 enables", {29'd0, out_valid, res_we, carry_we}, 32'd6);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] bound [14];
        bound = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF8000, 32'hFFFF7FFF,
                  32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFF, 32'h800000,
                  32'hFF800000, 32'hFF7FFFFF, 32'h12345678};
        repeat (3) @(negedge clk);
        chk(!out_valid && !res_we && !carry_we, "R1 in reset", {29'd0, out_valid, res_we, carry_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !res_we && !carry_we, "R1 after reset", {29'd0, out_valid, res_we, carry_we}, 32'd0);

        foreach (bound[i]) clamp_case(bound[i]);
        for (int k = -40000; k <= 40000; k += 397) clamp_case(32'(k));
        for (int k = -9000000; k <= 9000000; k += 77777) clamp_case(32'(k));
        for (int k = 0; k < 256; k++) clamp_case(32'(k) * 32'h01010101 ^ 32'h5A000000);

        // R2: out_valid drops when no issue follows
        @(negedge clk);
        chk(!out_valid && !res_we, "R2 idle drop", {31'd0, out_valid}, 32'd0);

        // R7 / R8: every bit position against every shift amount, upper amt bits noisy
        for (int k = 0; k < 32; k++) begin
            for (int s = 0; s < 64; s++) begin
                logic e;
                e = (k + (s % 32)) < 32;
                issue(2'd2, 32'd1 << k, 32'(s) | (32'(k) << 6));
                chk(carry == e, (s >= 32) ? "R8 upper amt ignored" : "R7 bit-search carry", {31'd0, carry}, {31'd0, e});
                chk(carry_we && !res_we && out_valid, "R7 bit-search enables", {30'd0, carry_we, res_we}, 32'd2);
            end
        end
        issue(2'd2, 32'd0, 32'd0);
        chk(carry == 1'b0, "R7 zero source", {31'd0, carry}, 32'd0);
        issue(2'd2, 32'hFFFFFFFF, 32'd32);
        chk(carry == 1'b1, "R8 amount 32 acts as zero", {31'd0, carry}, 32'd1);

        // R9: no-op code
        issue(2'd3, 32'h00123456, 32'd0);
        chk(out_valid && !res_we && !carry_we, "R9 no-op enables", {29'd0, out_valid, res_we, carry_we}, 32'd4);

        // R2: back-to-back issue
        @(negedge clk);
        op = 2'd0; src = 32'h00010000; in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid && res == 32'h7FFF, "R2 back-to-back first", res, 32'h7FFF);
        op = 2'd1; src = 32'h80000000;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && res == 32'hFF800000, "R2 back-to-back second", res, 32'hFF800000);
        @(negedge clk);
        chk(!out_valid, "R2 drop after burst", {31'd0, out_valid}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule